// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Controller

This block keeps a host processor in reset until conditions are safe, and puts it back into reset when something goes wrong. Three causes drive the single reset output. The first is a synchronous power-on request. The second is a low-supply indication from an external comparator, which reaches the block as one digital input. The third is the expiry of a watchdog timer. After every cause has gone away, the output stays active for a fixed stabilisation period before it is released.

The host keeps the watchdog alive by pulling its shared chip-select / watchdog-input line low. Only a falling edge on that line restarts the timer. The timeout is one of three prescaled intervals, or the watchdog is switched off. The choice lives in a selection register that stands in for non-volatile storage: the power-on request does not change it. A volatile flag tells the host whether the most recent reset came from the watchdog or from low supply. The output polarity is fixed by a parameter.

Top module: `host_supervisor`

## Requirements
- R1: While `por` is sampled high, the reset is active and `wd_flag` is 0. After the last rising edge that samples `por` high, the reset stays active through the next HOLD_TICKS×TICK_DIV rising edges and is released on the edge after those.
- R2: After a release with no falling edge on `cs_wdi`, the reset becomes active again T+1 rising edges after the release edge, where T is the selected tick count × TICK_DIV. It is then active for HOLD_TICKS×TICK_DIV further edges before it is released again.
- R3: The selection codes are 2'b00 for LONG_TICKS (default 1400), 2'b01 for MID_TICKS (default 600) and 2'b10 for SHORT_TICKS (default 200). Code 2'b11 turns the watchdog off, and it never expires while that code is held.
- R4: The selection register loads `cfg_sel` on a rising edge with `cfg_we` high. It starts at DEFAULT_SEL and keeps its value through `por`.
- R5: `vcc_low` passes through a two-stage synchronizer. The reset is active from the third rising edge after an edge that samples `vcc_low` high. Once the input returns low, the reset is released HOLD_TICKS×TICK_DIV+2 edges after the first edge that samples it low.
- R6: `wd_flag` rises on the same edge at which a watchdog expiry activates the reset. It is cleared when a low-supply reset begins.
- R7: `wd_flag` is cleared by `por` and by `flag_clr` sampled high. A watchdog expiry on the same edge as `flag_clr` wins.
- R8: Only a falling edge on the synchronized `cs_wdi` (a 1 sample followed by a 0 sample) restarts the watchdog. A rising edge, or a level held high or low, does not.
- R9: With RST_ACTIVE_HIGH=1, `rst_out` is 1 while the reset is active. With RST_ACTIVE_HIGH=0, it is 0 while the reset is active.
- R10: The watchdog does not count while the reset is active, and it starts from zero at each release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on request, active high, sampled on the clock |
| vcc_low | input | 1 | Low-supply comparator output, asynchronous |
| cs_wdi | input | 1 | Shared chip-select / watchdog restart line, asynchronous |
| cfg_we | input | 1 | Write strobe for the timeout selection register |
| cfg_sel | input | 2 | Timeout selection code to store |
| flag_clr | input | 1 | Command that clears the watchdog-cause flag |
| wd_flag | output | 1 | 1 when the most recent reset came from the watchdog |
| rst_out | output | 1 | Reset to the host, polarity set by RST_ACTIVE_HIGH |

## Verification
The assertions assume that `por` is high at time zero and stays high for at least one edge. They also assume that the tick counts are far larger than the three-edge synchronizer latency, so a `vcc_low` pulse always reaches the sequencer before any later check looks at it. The stimulus meets these assumptions: it starts with `por` asserted for several cycles, and it holds every `vcc_low` pulse for tens of cycles. It changes the selection code only during a reset or just before a power-on request, so the watchdog never sees its limit change mid-interval.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;

    // Timeout selection codes held in the persistent register
    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    // Event that the reset sequencer acts on in a given cycle
    typedef enum logic [1:0] {
        EV_NONE,
        EV_POWER,
        EV_SUPPLY,
        EV_WATCHDOG
    } rst_event_e;

    // Sequencer state carried from one cycle to the next
    typedef struct packed {
        logic active;
        logic wd_cause;
    } seq_state_t;

    function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic [31:0] sel_ticks(wd_sel_e s, int unsigned t_long,
                                              int unsigned t_mid, int unsigned t_short);
        case (s)
            WD_LONG:  return t_long;
            WD_MID:   return t_mid;
            WD_SHORT: return t_short;
            default:  return '1;
        endcase
    endfunction

endpackage

// File: rtl/sup_sync.sv
`timescale 1ns/1ps
module sup_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (clr) chain[0] <= RST_VAL;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (clr) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_interval_timer.sv
`timescale 1ns/1ps
module sup_interval_timer #(
    parameter int unsigned DIV = 4,
    parameter int unsigned TW  = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          done
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

    logic [PW-1:0] pre;
    logic [TW-1:0] ticks;

    assign done = (ticks >= limit);

    always_ff @(posedge clk) begin
        if (clr) begin
            pre   <= '0;
            ticks <= '0;
        end else if (en && !done) begin
            if (pre == PRE_LAST) begin
                pre   <= '0;
                ticks <= ticks + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_watchdog.sv
`timescale 1ns/1ps
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int unsigned DIV         = 4,
    parameter int unsigned TW          = 12,
    parameter int unsigned LONG_TICKS  = 1400,
    parameter int unsigned MID_TICKS   = 600,
    parameter int unsigned SHORT_TICKS = 200
) (
    input  logic    clk,
    input  logic    por,
    input  logic    wdi_sync,
    input  logic    hold_off,
    input  wd_sel_e sel,
    output logic    expired
);
    logic          wdi_prev;
    logic          wdi_fall;
    logic          restart;
    logic [TW-1:0] limit;

    always_ff @(posedge clk) begin
        if (por) wdi_prev <= 1'b1;
        else     wdi_prev <= wdi_sync;
    end

    assign wdi_fall = wdi_prev & ~wdi_sync;

    always_comb begin
        if (sel == WD_OFF) limit = '1;
        else               limit = TW'(sel_ticks(sel, LONG_TICKS, MID_TICKS, SHORT_TICKS));
    end

    assign restart = por | hold_off | wdi_fall | (sel == WD_OFF);

    sup_interval_timer #(.DIV(DIV), .TW(TW)) u_timer (
        .clk   (clk),
        .clr   (restart),
        .en    (1'b1),
        .limit (limit),
        .done  (expired)
    );
endmodule

// File: rtl/sup_reset_seq.sv
`timescale 1ns/1ps
module sup_reset_seq
    import sup_pkg::*;
#(
    parameter int unsigned DIV        = 4,
    parameter int unsigned TW         = 12,
    parameter int unsigned HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic por,
    input  logic lv,
    input  logic wd_expired,
    input  logic flag_clr,
    output logic in_rst,
    output logic flag
);
    localparam logic [TW-1:0] HOLD_LIM = TW'(HOLD_TICKS);

    seq_state_t cur, nxt;
    rst_event_e ev;
    logic       hold_done;
    logic       hold_clr;

    always_comb begin
        if (por)                        ev = EV_POWER;
        else if (lv)                    ev = EV_SUPPLY;
        else if (!cur.active && wd_expired) ev = EV_WATCHDOG;
        else                            ev = EV_NONE;
    end

    assign hold_clr = (ev != EV_NONE);

    sup_interval_timer #(.DIV(DIV), .TW(TW)) u_hold (
        .clk   (clk),
        .clr   (hold_clr),
        .en    (cur.active),
        .limit (HOLD_LIM),
        .done  (hold_done)
    );

    always_comb begin
        nxt = cur;
        case (ev)
            EV_POWER: begin
                nxt.active   = 1'b1;
                nxt.wd_cause = 1'b0;
            end
            EV_SUPPLY: begin
                nxt.active   = 1'b1;
                nxt.wd_cause = 1'b0;
            end
            EV_WATCHDOG: begin
                nxt.active   = 1'b1;
                nxt.wd_cause = 1'b1;
            end
            default: begin
                if (cur.active && hold_done) nxt.active = 1'b0;
                if (flag_clr)                nxt.wd_cause = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        cur <= nxt;
    end

    assign in_rst = cur.active;
    assign flag   = cur.wd_cause;
endmodule

// File: rtl/sup_cfg_store.sv
`timescale 1ns/1ps
module sup_cfg_store #(
    parameter logic [1:0] DEFAULT_SEL = 2'b00
) (
    input  logic       clk,
    input  logic       we,
    input  logic [1:0] wdata,
    output logic [1:0] sel
);
    // Stands in for non-volatile cells: loaded at configuration, never cleared by por
    logic [1:0] store = DEFAULT_SEL;

    always_ff @(posedge clk) begin
        if (we) store <= wdata;
    end

    assign sel = store;
endmodule

// File: rtl/host_supervisor.sv
`timescale 1ns/1ps
module host_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned TICK_DIV        = 200_000,
    parameter int unsigned LONG_TICKS      = 1400,
    parameter int unsigned MID_TICKS       = 600,
    parameter int unsigned SHORT_TICKS     = 200,
    parameter int unsigned HOLD_TICKS      = 200,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter bit          RST_ACTIVE_HIGH = 1'b1,
    parameter logic [1:0]  DEFAULT_SEL     = 2'b00
) (
    input  logic       clk,
    input  logic       por,
    input  logic       vcc_low,
    input  logic       cs_wdi,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    input  logic       flag_clr,
    output logic       wd_flag,
    output logic       rst_out
);
    localparam int unsigned MAX_TICKS = max_of4(LONG_TICKS, MID_TICKS, SHORT_TICKS, HOLD_TICKS);
    localparam int unsigned TICK_W    = $clog2(MAX_TICKS + 2);

    logic       lv_sync;
    logic       wdi_sync;
    logic [1:0] sel_q;
    logic       wd_expired;
    logic       in_rst;

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lv_sync (
        .clk (clk), .clr (por), .d (vcc_low), .q (lv_sync)
    );

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wdi_sync (
        .clk (clk), .clr (por), .d (cs_wdi), .q (wdi_sync)
    );

    sup_cfg_store #(.DEFAULT_SEL(DEFAULT_SEL)) u_cfg (
        .clk (clk), .we (cfg_we), .wdata (cfg_sel), .sel (sel_q)
    );

    sup_watchdog #(
        .DIV         (TICK_DIV),
        .TW          (TICK_W),
        .LONG_TICKS  (LONG_TICKS),
        .MID_TICKS   (MID_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_wd (
        .clk      (clk),
        .por      (por),
        .wdi_sync (wdi_sync),
        .hold_off (in_rst),
        .sel      (wd_sel_e'(sel_q)),
        .expired  (wd_expired)
    );

    sup_reset_seq #(
        .DIV        (TICK_DIV),
        .TW         (TICK_W),
        .HOLD_TICKS (HOLD_TICKS)
    ) u_seq (
        .clk        (clk),
        .por        (por),
        .lv         (lv_sync),
        .wd_expired (wd_expired),
        .flag_clr   (flag_clr),
        .in_rst     (in_rst),
        .flag       (wd_flag)
    );

    if (RST_ACTIVE_HIGH) begin : g_rst_high
        assign rst_out = in_rst;
    end else begin : g_rst_low
        assign rst_out = ~in_rst;
    end
endmodule

// File: rtl/sup_checker.sv
`timescale 1ns/1ps
module sup_checker (
    input logic       clk,
    input logic       por,
    input logic       vcc_low,
    input logic       in_rst,
    input logic       wd_flag,
    input logic       wd_expired,
    input logic [1:0] sel_q,
    input logic       lv_sync
);
    // R1
    por_hold_chk: assert property (@(posedge clk) disable iff (por)
        $fell(por) |-> in_rst);

    // R7
    por_flag_clear_chk: assert property (@(posedge clk) disable iff (por)
        $fell(por) |-> !wd_flag);

    // R5
    supply_reset_chk: assert property (@(posedge clk) disable iff (por)
        vcc_low |-> ##3 in_rst);

    // R5
    release_clean_chk: assert property (@(posedge clk) disable iff (por)
        $fell(in_rst) |-> !$past(lv_sync));

    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (por)
        $rose(wd_flag) |-> in_rst);

    // R3
    wd_off_chk: assert property (@(posedge clk) disable iff (por)
        (sel_q == 2'b11 && $past(sel_q) == 2'b11) |-> !wd_expired);

    // R10
    wd_idle_chk: assert property (@(posedge clk) disable iff (por)
        $past(in_rst) |-> !wd_expired);
endmodule

bind host_supervisor sup_checker u_chk (
    .clk        (clk),
    .por        (por),
    .vcc_low    (vcc_low),
    .in_rst     (in_rst),
    .wd_flag    (wd_flag),
    .wd_expired (wd_expired),
    .sel_q      (sel_q),
    .lv_sync    (lv_sync)
);

// File: tb/host_supervisor_test.sv
`timescale 1ns/1ps
module host_supervisor_test;
    localparam int DIV   = 4;
    localparam int LONG  = 1400;
    localparam int MID   = 600;
    localparam int SHORT = 200;
    localparam int HOLD  = 200;
    localparam int HOLDC = HOLD * DIV;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic vcc_low = 1'b0;
    logic cs_wdi = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic flag_clr = 1'b0;
    logic wd_flag, rst_out, flag_n, rst_out_n;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    host_supervisor #(.TICK_DIV(DIV), .LONG_TICKS(LONG), .MID_TICKS(MID),
        .SHORT_TICKS(SHORT), .HOLD_TICKS(HOLD), .RST_ACTIVE_HIGH(1'b1)) uut (
        .clk(clk), .por(por), .vcc_low(vcc_low), .cs_wdi(cs_wdi), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .flag_clr(flag_clr), .wd_flag(wd_flag), .rst_out(rst_out));

    host_supervisor #(.TICK_DIV(DIV), .LONG_TICKS(LONG), .MID_TICKS(MID),
        .SHORT_TICKS(SHORT), .HOLD_TICKS(HOLD), .RST_ACTIVE_HIGH(1'b0)) uut_n (
        .clk(clk), .por(por), .vcc_low(vcc_low), .cs_wdi(cs_wdi), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .flag_clr(flag_clr), .wd_flag(flag_n), .rst_out(rst_out_n));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: input histories as queues, elapsed cycles as integers
    bit m_rst = 1'b1;
    bit m_flag = 1'b0;
    int m_sel = 0;
    int m_wd = 0;
    int m_hold = 0;
    bit lvq[$] = '{1'b0, 1'b0, 1'b0};
    bit wq[$]  = '{1'b1, 1'b1, 1'b1};

    always @(posedge clk) begin
        bit lvs, fall, wd_hit, hold_hit;
        int lim;
        lvs  = lvq[1];
        fall = wq[2] && !wq[1];
        lim  = (m_sel == 0) ? LONG * DIV : (m_sel == 1) ? MID * DIV : SHORT * DIV;
        wd_hit   = (m_sel != 3) && (m_wd >= lim);
        hold_hit = (m_hold >= HOLDC);
        if (por) begin
            m_rst = 1'b1; m_hold = 0; m_wd = 0; m_flag = 1'b0;
            lvq = '{1'b0, 1'b0, 1'b0};
            wq  = '{1'b1, 1'b1, 1'b1};
        end else begin
            if (m_rst || fall || m_sel == 3) m_wd = 0;
            else if (!wd_hit) m_wd++;
            if (lvs) begin
                m_rst = 1'b1; m_hold = 0; m_flag = 1'b0;
            end else if (m_rst) begin
                if (hold_hit) m_rst = 1'b0; else m_hold++;
                if (flag_clr) m_flag = 1'b0;
            end else if (wd_hit) begin
                m_rst = 1'b1; m_hold = 0; m_flag = 1'b1;
            end else if (flag_clr) begin
                m_flag = 1'b0;
            end
            lvq.push_front(vcc_low); void'(lvq.pop_back());
            wq.push_front(cs_wdi);   void'(wq.pop_back());
        end
        if (cfg_we) m_sel = int'(cfg_sel);
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check(rst_out == m_rst, cur_req, rst_out, m_rst);
            check(wd_flag == m_flag, "R6", wd_flag, m_flag);
            check(rst_out_n == !m_rst, "R9", rst_out_n, !m_rst);
            check(flag_n == m_flag, "R9", flag_n, m_flag);
        end
    end

    task automatic count_while(input logic level, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (rst_out != level || n > 20000) break;
            n++;
        end
    endtask

    task automatic write_sel(input logic [1:0] v);
        cfg_sel = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_por();
        por = 1'b1;
        repeat (3) @(negedge clk);
        por = 1'b0;
    endtask

    initial begin
        int n;
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1 reset state while por is held
        check(rst_out == 1'b1, "R1", rst_out, 1);
        check(wd_flag == 1'b0, "R1", wd_flag, 0);
        check(rst_out_n == 1'b0, "R9", rst_out_n, 0);
        cmp_en = 1'b1;

        // R1 stabilisation period, then R3 long default and R2 expiry
        cur_req = "R1";
        por = 1'b0;
        count_while(1'b1, n); check(n == HOLDC, "R1", n, HOLDC);
        cur_req = "R2";
        count_while(1'b0, n); check(n == LONG * DIV, "R3", n, LONG * DIV);
        check(wd_flag == 1'b1, "R6", wd_flag, 1);
        count_while(1'b1, n); check(n == HOLDC, "R2", n, HOLDC);

        // R7 por clears flag; R4 selection survives por
        cur_req = "R4";
        write_sel(2'b10);
        pulse_por();
        check(wd_flag == 1'b0, "R7", wd_flag, 0);
        count_while(1'b1, n); check(n == HOLDC, "R1", n, HOLDC);
        count_while(1'b0, n); check(n == SHORT * DIV, "R4", n, SHORT * DIV);
        check(wd_flag == 1'b1, "R6", wd_flag, 1);

        // R7 flag_clr during hold
        cur_req = "R7";
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
        check(wd_flag == 1'b0, "R7", wd_flag, 0);
        count_while(1'b1, n);

        // R8 periodic falling edges keep the host out of reset
        cur_req = "R8";
        n = 0;
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 500; c++) begin @(negedge clk); if (rst_out) n++; end
            cs_wdi = 1'b0; repeat (3) @(negedge clk); cs_wdi = 1'b1;
        end
        check(n == 0, "R8", n, 0);
        count_while(1'b0, n);
        // hold the line low from inside the reset: level gives no restart
        cs_wdi = 1'b0;
        count_while(1'b1, n);
        count_while(1'b0, n); check(n == SHORT * DIV, "R8", n, SHORT * DIV);
        count_while(1'b1, n);
        // rising edge outside reset gives no restart
        repeat (300) @(negedge clk);
        check(rst_out == 1'b0, "R8", rst_out, 0);
        cs_wdi = 1'b1;
        count_while(1'b0, n); check(n == SHORT * DIV - 300, "R8", n, SHORT * DIV - 300);

        // R3 middle interval, written during the hold
        cur_req = "R3";
        write_sel(2'b01);
        count_while(1'b1, n);
        count_while(1'b0, n); check(n == MID * DIV, "R3", n, MID * DIV);

        // R3 watchdog off
        write_sel(2'b11);
        count_while(1'b1, n);
        n = 0;
        for (int c = 0; c < 7000; c++) begin @(negedge clk); if (rst_out) n++; end
        check(n == 0, "R3", n, 0);
        check(wd_flag == 1'b1, "R6", wd_flag, 1);

        // R5 low supply, R6 flag cleared by it, R10 fresh watchdog after release
        cur_req = "R5";
        vcc_low = 1'b1;
        write_sel(2'b10);
        repeat (40) @(negedge clk);
        check(rst_out == 1'b1, "R5", rst_out, 1);
        check(wd_flag == 1'b0, "R6", wd_flag, 0);
        vcc_low = 1'b0;
        count_while(1'b1, n); check(n == HOLDC + 2, "R5", n, HOLDC + 2);
        cur_req = "R10";
        count_while(1'b0, n); check(n == SHORT * DIV, "R10", n, SHORT * DIV);
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule